// File: doc/BRIEF.md
# Framed Serial Transmitter with Sticky Error Flags

This block is the sending half of a frame-synchronised serial port. A host pushes 16-bit words into a 16-entry transmit queue through a simple write strobe. Each frame-sync pulse starts one slot: the shift engine takes the next queued word and drives it out on a single serial line, one bit per clock, most significant bit first.

Three error conditions are recorded as sticky bits in an 8-bit status word:

- **Sync-too-early (bit 4):** a sync pulse arrives before the current slot has finished.
- **Queue overflow (bit 3):** a write arrives while the queue is full.
- **Queue starvation (bit 2):** a slot starts with the queue empty.

The host clears a bit by writing a 1 to its position. Each bit can be routed to one shared error interrupt line through its own enable.

The block keeps running when an error occurs. Overflowing words are dropped. A starved slot repeats the word sent before it. An early sync abandons the unfinished slot and starts the next one at once.

Top module: `fstx_top`

## Requirements
- R1: Words written with `wr_valid` while fewer than 16 are queued are accepted, counted in `fifo_level`, and later transmitted in the order they were written.
- R2: A write while `fifo_level` is 16 is dropped and leaves `fifo_level` at 16. If `tx_en` is 1, status bit 3 is set.
- R3: When `fsync` is sampled high with `tx_en` at 1, the next queued word appears on `txd`. Its bit 15 is shown in the cycle after the sync edge, and bits 14 down to 0 follow on the next 15 cycles. `txd` is 0 whenever no slot is active.
- R4: A slot started with `tx_en` at 1 and an empty queue repeats the last word taken from the queue and sets status bit 2. If no word has been taken since reset, it sends all zeros.
- R5: A sync pulse sampled while two or more bits of the current slot remain sets status bit 4 when `tx_en` or `rx_en` is 1. A sync sampled while the final bit is on the line is not an error.
- R6: After an early sync, the unfinished slot is abandoned and the next word is sent complete, starting in the cycle after the early sync.
- R7: Writing `sta_we` with a 1 in bit 4, 3 or 2 of `sta_wdata` clears that status bit. A 0 leaves the bit unchanged. A set event in the same cycle overrides the clear.
- R8: `err_irq` is 1 exactly when a set status bit has its enable set. `err_ie[2]` enables bit 4, `err_ie[1]` enables bit 3 and `err_ie[0]` enables bit 2.
- R9: After reset, `status`, `fifo_level`, `txd` and `err_irq` are all 0.
- R10: With `tx_en` at 0, sync pulses take no word from the queue, `txd` stays 0, and status bits 3 and 2 are never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable; only qualifies the sync error |
| wr_valid | input | 1 | Host write strobe for the queue |
| wr_data | input | 16 | Word to queue |
| fsync | input | 1 | Frame-sync pulse, one cycle wide |
| sta_we | input | 1 | Status write strobe (write-1-to-clear) |
| sta_wdata | input | 8 | Clear mask; bits 4, 3 and 2 are used |
| err_ie | input | 3 | Interrupt enables for status bits 4, 3, 2 |
| txd | output | 1 | Serial data out |
| status | output | 8 | Sticky flags: bit 4 sync, bit 3 overflow, bit 2 starvation |
| err_irq | output | 1 | Shared error interrupt |
| fifo_level | output | 5 | Number of queued words, 0 to 16 |

## Verification
Some rules are checked by assertions on every clock:

- each of the three errors sets its flag on the next edge;
- a dropped write leaves the queue full;
- flags stay set until cleared;
- a clear without a competing set takes effect;
- the level never exceeds the queue depth.

Other behaviour only the bench scenarios can show. This covers the actual bit sequence on `txd`, the queue order, the repeated word after starvation (including the all-zero case after reset), the complete resend after an early sync, and the exact boundary where a sync is not early.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned FSE_BIT  = 4;
   localparam int unsigned OVR_BIT  = 3;
   localparam int unsigned UDR_BIT  = 2;

   typedef struct packed {
      logic fse;
      logic ovr;
      logic udr;
   } err_ev_t;
endpackage

// File: rtl/fstx_fifo.sv
module fstx_fifo #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DW-1:0]              din,
   input  logic                       pop,
   output logic [DW-1:0]              dout,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       full,
   output logic                       empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fstx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter #(
   parameter int unsigned DW        = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync,
   input  logic          tx_en,
   input  logic          q_empty,
   input  logic [DW-1:0] q_head,
   output logic          q_pop,
   output logic          txd,
   output logic          early,
   output logic          starve
);
   localparam int unsigned CW = $clog2(DW + 1);

   if (DW < 2) begin : g_bad_width
      $error("fstx_shifter: DW must be at least 2");
   end

   logic [CW-1:0] bits_left;
   logic [DW-1:0] shreg, prev_word;
   logic          load, out_bit;

   assign early  = sync && (bits_left > CW'(1));
   assign load   = sync && tx_en;
   assign q_pop  = load && !q_empty;
   assign starve = load && q_empty;

   if (MSB_FIRST) begin : g_msb
      assign out_bit = shreg[DW-1];
   end else begin : g_lsb
      assign out_bit = shreg[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_left <= '0;
         shreg     <= '0;
         prev_word <= '0;
      end else begin
         if (sync)                bits_left <= CW'(DW);
         else if (bits_left != 0) bits_left <= bits_left - 1'b1;

         if (load) begin
            shreg <= q_empty ? prev_word : q_head;
            if (!q_empty) prev_word <= q_head;
         end else if (bits_left != 0) begin
            shreg <= MSB_FIRST ? {shreg[DW-2:0], 1'b0} : {1'b0, shreg[DW-1:1]};
         end
      end
   end

   assign txd = tx_en && (bits_left != 0) && out_bit;
endmodule

// File: rtl/fstx_errflags.sv
module fstx_errflags
   import fstx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  err_ev_t           ev,
   input  logic              clr_we,
   input  err_ev_t           clr_sel,
   input  logic [2:0]        ie,
   output logic [STAT_W-1:0] status,
   output logic              irq
);
   err_ev_t flags, clr;

   assign clr = clr_we ? clr_sel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= ev | (flags & ~clr);
   end

   always_comb begin
      status          = '0;
      status[FSE_BIT] = flags.fse;
      status[OVR_BIT] = flags.ovr;
      status[UDR_BIT] = flags.udr;
   end

   assign irq = |({flags.fse, flags.ovr, flags.udr} & ie);
endmodule

// File: rtl/fstx_top.sv
module fstx_top
   import fstx_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned DEPTH     = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tx_en,
   input  logic                   rx_en,
   input  logic                   wr_valid,
   input  logic [DW-1:0]          wr_data,
   input  logic                   fsync,
   input  logic                   sta_we,
   input  logic [STAT_W-1:0]      sta_wdata,
   input  logic [2:0]             err_ie,
   output logic                   txd,
   output logic [STAT_W-1:0]      status,
   output logic                   err_irq,
   output logic [$clog2(DEPTH):0] fifo_level
);
   logic [DW-1:0] q_head;
   logic          q_pop, q_full, q_empty;
   logic          early_w, starve_w;
   err_ev_t       ev, clr_sel;
   logic          unused_wbits;

   assign unused_wbits = ^{sta_wdata[STAT_W-1:FSE_BIT+1], sta_wdata[UDR_BIT-1:0]};

   fstx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_valid), .din(wr_data),
      .pop(q_pop), .dout(q_head), .level(fifo_level),
      .full(q_full), .empty(q_empty)
   );

   fstx_shifter #(.DW(DW), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .sync(fsync), .tx_en(tx_en),
      .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
      .txd(txd), .early(early_w), .starve(starve_w)
   );

   assign ev.fse  = early_w && (tx_en || rx_en);
   assign ev.ovr  = wr_valid && q_full && tx_en;
   assign ev.udr  = starve_w;

   assign clr_sel.fse = sta_wdata[FSE_BIT];
   assign clr_sel.ovr = sta_wdata[OVR_BIT];
   assign clr_sel.udr = sta_wdata[UDR_BIT];

   fstx_errflags u_flags (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr_we(sta_we),
      .clr_sel(clr_sel), .ie(err_ie), .status(status), .irq(err_irq)
   );
endmodule

// File: rtl/fstx_chk.sv
module fstx_chk #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tx_en,
   input logic                   rx_en,
   input logic                   wr_valid,
   input logic                   fsync,
   input logic                   sta_we,
   input logic [7:0]             sta_wdata,
   input logic [7:0]             status,
   input logic [$clog2(DEPTH):0] fifo_level,
   input logic                   early
);
   logic full_c;
   assign full_c = (fifo_level == ($clog2(DEPTH) + 1)'(DEPTH));

   a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= ($clog2(DEPTH) + 1)'(DEPTH));

   a_r2_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && tx_en && full_c |=> status[3]);

   a_r2_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && full_c && !(fsync && tx_en) |=> full_c);

   a_r4_starve_flag: assert property (@(posedge clk) disable iff (!rst_n)
      fsync && tx_en && fifo_level == '0 |=> status[2]);

   a_r5_sync_flag: assert property (@(posedge clk) disable iff (!rst_n)
      early && (tx_en || rx_en) |=> status[4]);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] && !(sta_we && sta_wdata[4]) |=> status[4]);

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sta_we && sta_wdata[3] && !(wr_valid && tx_en && full_c) |=> !status[3]);
endmodule

bind fstx_top fstx_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
   .wr_valid(wr_valid), .fsync(fsync), .sta_we(sta_we),
   .sta_wdata(sta_wdata), .status(status), .fifo_level(fifo_level),
   .early(early_w)
);

// File: tb/fstx_top_tb_top.sv
`timescale 1ns/1ps
module fstx_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0, rx_en = 1'b0, wr_valid = 1'b0, fsync = 1'b0, sta_we = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  sta_wdata = '0;
   logic [2:0]  err_ie = '0;
   logic        txd, err_irq;
   logic [7:0]  status;
   logic [4:0]  fifo_level;

   int total = 0;
   int bad   = 0;

   localparam int NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{16'hA5C3, 16'h8001, 16'h7FFE,
                                         16'hFFFF, 16'h0000, 16'h1234};

   always #2.5 clk = ~clk;

   fstx_top dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .fsync(fsync),
      .sta_we(sta_we), .sta_wdata(sta_wdata), .err_ie(err_ie),
      .txd(txd), .status(status), .err_irq(err_irq), .fifo_level(fifo_level)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic push(input logic [15:0] w);
      wr_valid = 1'b1; wr_data = w;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic clr(input logic [7:0] m);
      sta_we = 1'b1; sta_wdata = m;
      @(negedge clk);
      sta_we = 1'b0; sta_wdata = '0;
   endtask

   task automatic collect(input int n, output logic [15:0] w);
      w = '0;
      for (int k = 0; k < n; k++) begin
         w = {w[14:0], txd};
         @(negedge clk);
      end
   endtask

   task automatic frame(output logic [15:0] w);
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      collect(16, w);
   endtask

   function automatic logic [15:0] fillw(input int i);
      logic [3:0] n = 4'(i);
      return {n, ~n, n ^ 4'h5, 4'hC};
   endfunction

   initial begin
      logic [15:0] w, w2;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 status", 32'(status), 32'h00);
      check("R9 level", 32'(fifo_level), 32'd0);
      check("R9 txd", 32'(txd), 32'd0);
      check("R9 irq", 32'(err_irq), 32'd0);
      rst_n = 1'b1;
      tx_en = 1'b1;
      @(negedge clk);

      // R4: starvation right after reset sends zeros
      frame(w);
      check("R4 zero resend", 32'(w), 32'h0000);
      check("R4 flag", 32'(status), 32'h04);
      err_ie = 3'b001; #0.1;
      check("R8 irq udr en", 32'(err_irq), 32'd1);
      err_ie = 3'b110; #0.1;
      check("R8 irq udr masked", 32'(err_irq), 32'd0);
      err_ie = 3'b000;

      // R7: write 0 keeps, write 1 clears
      clr(8'h00);
      check("R7 write0 keeps", 32'(status), 32'h04);
      clr(8'h04);
      check("R7 write1 clears", 32'(status), 32'h00);

      // R1/R3: vector table walk
      for (int i = 0; i < NVEC; i++) push(VEC[i]);
      check("R1 level after pushes", 32'(fifo_level), 32'(NVEC));
      for (int i = 0; i < NVEC; i++) begin
         frame(w);
         check($sformatf("R3 vec%0d", i), 32'(w), 32'(VEC[i]));
      end
      check("R3 idle txd", 32'(txd), 32'd0);
      check("R1 drained", 32'(fifo_level), 32'd0);

      // R4: starvation repeats last word
      frame(w);
      check("R4 resend last", 32'(w), 32'h1234);
      check("R4 flag again", 32'(status), 32'h04);
      clr(8'h04);

      // R2: overflow
      for (int i = 0; i < 16; i++) push(fillw(i));
      check("R1 full level", 32'(fifo_level), 32'd16);
      push(16'hDEAD);
      check("R2 level held", 32'(fifo_level), 32'd16);
      check("R2 flag", 32'(status), 32'h08);
      sta_we = 1'b1; sta_wdata = 8'h08; wr_valid = 1'b1; wr_data = 16'hBEEF;
      @(negedge clk);
      sta_we = 1'b0; sta_wdata = '0; wr_valid = 1'b0;
      check("R7 set wins", 32'(status), 32'h08);
      clr(8'h08);
      check("R7 ovr cleared", 32'(status), 32'h00);
      tx_en = 1'b0;
      push(16'hDEAD);
      check("R10 no ovr flag", 32'(status), 32'h00);
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      check("R10 no pop", 32'(fifo_level), 32'd16);
      collect(16, w);
      check("R10 txd quiet", 32'(w), 32'h0000);
      check("R10 no udr", 32'(status), 32'h00);
      tx_en = 1'b1;
      for (int i = 0; i < 16; i++) begin
         frame(w);
         check($sformatf("R1 order %0d", i), 32'(w), 32'(fillw(i)));
      end
      frame(w);
      check("R2 dropped word not sent", 32'(w), 32'(fillw(15)));
      clr(8'h04);

      // R5 boundary: sync on last bit is not early
      push(16'h3C5A); push(16'h9696);
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      collect(15, w);
      w = {w[14:0], txd};
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      check("R5 boundary word1", 32'(w), 32'h3C5A);
      collect(16, w2);
      check("R5 boundary word2", 32'(w2), 32'h9696);
      check("R5 boundary no flag", 32'(status), 32'h00);

      // R5/R6: early sync
      push(16'hA1A1); push(16'hB2B2);
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      collect(5, w);
      check("R3 partial bits", 32'(w[4:0]), 32'(5'b10100));
      frame(w2);
      check("R6 next word whole", 32'(w2), 32'hB2B2);
      check("R5 early flag", 32'(status), 32'h10);
      err_ie = 3'b100; #0.1;
      check("R8 irq fse en", 32'(err_irq), 32'd1);
      err_ie = 3'b011; #0.1;
      check("R8 irq fse masked", 32'(err_irq), 32'd0);
      err_ie = 3'b000;
      clr(8'h10);

      // R5/R10: receive-only early sync
      tx_en = 1'b0; rx_en = 1'b1;
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      repeat (3) @(negedge clk);
      fsync = 1'b1; @(negedge clk); fsync = 1'b0;
      check("R5 rx-only flag", 32'(status), 32'h10);
      check("R10 rx-only txd", 32'(txd), 32'd0);
      check("R10 rx-only level", 32'(fifo_level), 32'd0);
      rx_en = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule